// File: doc/BRIEF.md
# Grid Stage Packet Steering and Merge Unit

This unit is one stage in a row of packet processing stages. Packets enter on a valid/ready stream in the fabric clock domain. The first beat of every packet is a control header, and four of its bits (27 to 30) each select one stage in the row. The stage reads its own bit on the header beat and steers the whole packet one of two ways. If the bit is set, the packet goes to the local processing engine. If it is clear, the packet goes into a bypass buffer.

The engine runs on its own, slower clock. Packets reach it through a dual-clock FIFO whose pointers cross domains in Gray code. Packets it sends back return through a second dual-clock FIFO. Those returned packets may be longer than the originals, for example because a statistics trailer has been appended. A two-input round-robin arbiter then merges the returned packets with the bypassed packets, one whole packet at a time, and drives the next stage in the row. In this block the engine itself is replaced by a pair of stream ports.

Every stream here follows the same rules. A beat transfers on a rising edge where valid and ready are both high. A source must not drop valid, or change data or last, until its beat is taken. A sink may hold ready low for any length of time. When a buffer fills, back-pressure passes upstream to `in_tready`, and no beat is dropped.

Top module: `grid_unit_stage`

## Requirements
- R1: After reset, `out_tvalid` and `core_tx_tvalid` are low and `in_tready` is high.
- R2: A packet whose header beat has bit 27+UNIT_IDX set appears on the core transmit port. All of its beats appear there, unchanged and in order.
- R3: A packet whose header beat has bit 27+UNIT_IDX clear appears on `out_*` through the bypass buffer. Its beats are unchanged and in order, and it never reaches the core port.
- R4: The routing choice is made only on the header beat. The rest of that packet follows it up to and including tlast, whatever values the later beats carry in bits 27 to 30.
- R5: Both clock crossings deliver every beat exactly once and in order, with any stall pattern on the core-side ready.
- R6: Once a packet starts on `out_*`, every beat up to its tlast comes from the same source. Packets from the core and the bypass path never interleave.
- R7: Suppose a whole packet is waiting on both merge inputs when a packet ends. The input that did not send the previous packet goes next.
- R8: While `out_tvalid` is high and `out_tready` is low, `out_tvalid`, `out_tdata` and `out_tlast` stay constant.
- R9: When the buffer chosen for the current packet is full, `in_tready` goes low and the buffer takes no further beats. The bypass buffer holds exactly BYP_DEPTH beats.
- R10: Packets the core returns on `core_rx_*` appear on `out_*` unchanged, including any trailer beats added to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fab | input | 1 | Fabric clock |
| rst_fab_n | input | 1 | Active-low reset, fabric domain |
| clk_core | input | 1 | Core clock |
| rst_core_n | input | 1 | Active-low reset, core domain |
| in_tdata | input | DW | Incoming beat; header on the first beat |
| in_tlast | input | 1 | Last beat of incoming packet |
| in_tvalid | input | 1 | Incoming beat valid |
| in_tready | output | 1 | Stage accepts incoming beat |
| core_tx_tdata | output | DW | Beat toward the core |
| core_tx_tlast | output | 1 | Last beat toward the core |
| core_tx_tvalid | output | 1 | Beat toward the core valid |
| core_tx_tready | input | 1 | Core accepts beat |
| core_rx_tdata | input | DW | Beat returned by the core |
| core_rx_tlast | input | 1 | Last returned beat |
| core_rx_tvalid | input | 1 | Returned beat valid |
| core_rx_tready | output | 1 | Stage accepts returned beat |
| out_tdata | output | DW | Merged beat to the next stage |
| out_tlast | output | 1 | Last merged beat |
| out_tvalid | output | 1 | Merged beat valid |
| out_tready | input | 1 | Next stage accepts beat |

## Verification
The hardest case to reach from the ports is a packet boundary where complete packets sit on both merge inputs at the same moment. Returned packets pass through two clock crossings and a core model, so their arrival time cannot be steered directly. To get there, the bench holds `out_tready` low while it sends alternating core-bound and bypass packets. It then waits long enough for both paths to fill, and only then opens the output, checking that the packet sources alternate. A second stall, with the output held closed during a single long bypass packet, fills the bypass buffer exactly, so that input back-pressure can be observed.

// File: rtl/grid_stage_pkg.sv
package grid_stage_pkg;
  typedef enum logic {SRC_CORE = 1'b0, SRC_BYP = 1'b1} merge_src_e;
  localparam int ROUTE_FIELD_LSB = 27;
  localparam int ROUTE_FIELD_W   = 4;
endpackage

// File: rtl/gs_cdc_fifo.sv
module gs_cdc_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic [W-1:0] w_data,
  input  logic         w_valid,
  output logic         w_ready,
  input  logic         rclk,
  input  logic         rrst_n,
  output logic [W-1:0] r_data,
  output logic         r_valid,
  input  logic         r_ready
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0] wbin, wgray, rbin, rgray;
  logic [AW:0] w_sync1, w_sync2;   // read pointer seen in write domain
  logic [AW:0] r_sync1, r_sync2;   // write pointer seen in read domain
  logic [AW:0] wbin_nxt, rbin_nxt;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side
  assign wbin_nxt = wbin + 1'b1;
  assign w_ready  = (wgray != {~w_sync2[AW:AW-1], w_sync2[AW-2:0]});

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin    <= '0;
      wgray   <= '0;
      w_sync1 <= '0;
      w_sync2 <= '0;
    end else begin
      w_sync1 <= rgray;
      w_sync2 <= w_sync1;
      if (w_valid && w_ready) begin
        wbin  <= wbin_nxt;
        wgray <= to_gray(wbin_nxt);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (w_valid && w_ready) mem[wbin[AW-1:0]] <= w_data;
  end

  // read side
  assign rbin_nxt = rbin + 1'b1;
  assign r_valid  = (rgray != r_sync2);
  assign r_data   = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin    <= '0;
      rgray   <= '0;
      r_sync1 <= '0;
      r_sync2 <= '0;
    end else begin
      r_sync1 <= wgray;
      r_sync2 <= r_sync1;
      if (r_valid && r_ready) begin
        rbin  <= rbin_nxt;
        rgray <= to_gray(rbin_nxt);
      end
    end
  end

  // occupancy as each side sees it never exceeds the storage
  logic [AW:0] w_occ, r_occ;
  assign w_occ = wbin - from_gray(w_sync2);
  assign r_occ = from_gray(r_sync2) - rbin;

  assert_no_overflow_R9: assert property (@(posedge wclk) disable iff (!wrst_n)
    w_occ <= (AW+1)'(DEPTH));
  assert_no_underflow_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    r_occ <= (AW+1)'(DEPTH));
endmodule

// File: rtl/gs_sync_fifo.sv
module gs_sync_fifo #(
  parameter int W     = 33,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] w_data,
  input  logic         w_valid,
  output logic         w_ready,
  output logic [W-1:0] r_data,
  output logic         r_valid,
  input  logic         r_ready
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, pop;

  assign w_ready = (cnt != (AW+1)'(DEPTH));
  assign r_valid = (cnt != '0);
  assign r_data  = mem[rp];
  assign push    = w_valid && w_ready;
  assign pop     = r_valid && r_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= w_data;
  end

  assert_byp_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (AW+1)'(DEPTH)) |=> (cnt == (AW+1)'(DEPTH)) || !r_ready || $past(r_ready));
endmodule

// File: rtl/gs_dispatch.sv
module gs_dispatch
  import grid_stage_pkg::*;
#(
  parameter int DW       = 32,
  parameter int UNIT_IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  input  logic          s_valid,
  output logic          s_ready,
  output logic          core_valid,
  input  logic          core_ready,
  output logic          byp_valid,
  input  logic          byp_ready
);
  localparam int ROUTE_BIT = ROUTE_FIELD_LSB + UNIT_IDX;

  logic mid_pkt, held_core, to_core;

  assign to_core    = mid_pkt ? held_core : s_data[ROUTE_BIT];
  assign core_valid = s_valid && to_core;
  assign byp_valid  = s_valid && !to_core;
  assign s_ready    = to_core ? core_ready : byp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_pkt   <= 1'b0;
      held_core <= 1'b0;
    end else if (s_valid && s_ready) begin
      mid_pkt   <= !s_last;
      held_core <= to_core;
    end
  end

  assert_route_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !s_last) |=> (s_valid |-> (core_valid == $past(core_valid))));
endmodule

// File: rtl/gs_rr_merge.sv
module gs_rr_merge
  import grid_stage_pkg::*;
#(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_data,
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] b_data,
  input  logic         b_valid,
  output logic         b_ready,
  output logic [W-1:0] m_data,
  output logic         m_valid,
  input  logic         m_ready
);
  merge_src_e owner, last_src, pick, sel;
  logic busy, m_last;

  always_comb begin
    if (a_valid && b_valid) pick = (last_src == SRC_CORE) ? SRC_BYP : SRC_CORE;
    else if (a_valid)       pick = SRC_CORE;
    else                    pick = SRC_BYP;
  end

  assign sel     = busy ? owner : pick;
  assign m_data  = (sel == SRC_CORE) ? a_data : b_data;
  assign m_valid = (sel == SRC_CORE) ? a_valid : b_valid;
  assign m_last  = m_data[W-1];
  assign a_ready = m_ready && (sel == SRC_CORE);
  assign b_ready = m_ready && (sel == SRC_BYP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      owner    <= SRC_CORE;
      last_src <= SRC_BYP;
    end else if (m_valid) begin
      if (m_ready && m_last) begin
        busy     <= 1'b0;
        last_src <= sel;
      end else begin
        busy  <= 1'b1;
        owner <= sel;
      end
    end
  end

  assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));
  assert_no_interleave_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !m_last) |=> (sel == $past(sel)));
endmodule

// File: rtl/grid_unit_stage.sv
module grid_unit_stage
  import grid_stage_pkg::*;
#(
  parameter int DW        = 32,
  parameter int UNIT_IDX  = 0,
  parameter int CDC_DEPTH = 16,
  parameter int BYP_DEPTH = 16
) (
  input  logic          clk_fab,
  input  logic          rst_fab_n,
  input  logic          clk_core,
  input  logic          rst_core_n,
  input  logic [DW-1:0] in_tdata,
  input  logic          in_tlast,
  input  logic          in_tvalid,
  output logic          in_tready,
  output logic [DW-1:0] core_tx_tdata,
  output logic          core_tx_tlast,
  output logic          core_tx_tvalid,
  input  logic          core_tx_tready,
  input  logic [DW-1:0] core_rx_tdata,
  input  logic          core_rx_tlast,
  input  logic          core_rx_tvalid,
  output logic          core_rx_tready,
  output logic [DW-1:0] out_tdata,
  output logic          out_tlast,
  output logic          out_tvalid,
  input  logic          out_tready
);
  localparam int BW = DW + 1;   // beat = {last, data}

  logic [BW-1:0] in_beat, tx_beat, rx_beat, ret_beat, byp_beat, out_beat;
  logic to_core_valid, to_core_ready, to_byp_valid, to_byp_ready;
  logic ret_valid, ret_ready, byp_valid, byp_ready;

  assign in_beat = {in_tlast, in_tdata};
  assign rx_beat = {core_rx_tlast, core_rx_tdata};

  gs_dispatch #(.DW(DW), .UNIT_IDX(UNIT_IDX)) u_dispatch (
    .clk(clk_fab), .rst_n(rst_fab_n),
    .s_data(in_tdata), .s_last(in_tlast), .s_valid(in_tvalid), .s_ready(in_tready),
    .core_valid(to_core_valid), .core_ready(to_core_ready),
    .byp_valid(to_byp_valid), .byp_ready(to_byp_ready)
  );

  gs_cdc_fifo #(.W(BW), .DEPTH(CDC_DEPTH)) u_to_core (
    .wclk(clk_fab), .wrst_n(rst_fab_n),
    .w_data(in_beat), .w_valid(to_core_valid), .w_ready(to_core_ready),
    .rclk(clk_core), .rrst_n(rst_core_n),
    .r_data(tx_beat), .r_valid(core_tx_tvalid), .r_ready(core_tx_tready)
  );

  assign core_tx_tlast = tx_beat[DW];
  assign core_tx_tdata = tx_beat[DW-1:0];

  gs_cdc_fifo #(.W(BW), .DEPTH(CDC_DEPTH)) u_from_core (
    .wclk(clk_core), .wrst_n(rst_core_n),
    .w_data(rx_beat), .w_valid(core_rx_tvalid), .w_ready(core_rx_tready),
    .rclk(clk_fab), .rrst_n(rst_fab_n),
    .r_data(ret_beat), .r_valid(ret_valid), .r_ready(ret_ready)
  );

  gs_sync_fifo #(.W(BW), .DEPTH(BYP_DEPTH)) u_bypass (
    .clk(clk_fab), .rst_n(rst_fab_n),
    .w_data(in_beat), .w_valid(to_byp_valid), .w_ready(to_byp_ready),
    .r_data(byp_beat), .r_valid(byp_valid), .r_ready(byp_ready)
  );

  gs_rr_merge #(.W(BW)) u_merge (
    .clk(clk_fab), .rst_n(rst_fab_n),
    .a_data(ret_beat), .a_valid(ret_valid), .a_ready(ret_ready),
    .b_data(byp_beat), .b_valid(byp_valid), .b_ready(byp_ready),
    .m_data(out_beat), .m_valid(out_tvalid), .m_ready(out_tready)
  );

  assign out_tlast = out_beat[DW];
  assign out_tdata = out_beat[DW-1:0];

  assert_in_stall_R9: assert property (@(posedge clk_fab) disable iff (!rst_fab_n)
    (in_tvalid && !in_tready) |-> (to_core_valid ? !to_core_ready : !to_byp_ready));
endmodule

// File: tb/grid_unit_stage_test.sv
`timescale 1ns/100ps
module grid_unit_stage_test;
  localparam int DW = 32, UNIT = 2, CDC_D = 16, BYP_D = 16;

  logic clk_fab = 0, clk_core = 0, rst_fab_n = 0, rst_core_n = 0;
  always #4 clk_fab = ~clk_fab;    // 125 MHz
  always #6 clk_core = ~clk_core;

  logic [DW-1:0] in_tdata = '0, core_tx_tdata, core_rx_tdata = '0, out_tdata;
  logic in_tlast = 0, in_tvalid = 0, in_tready;
  logic core_tx_tlast, core_tx_tvalid, core_tx_tready = 0;
  logic core_rx_tlast = 0, core_rx_tvalid = 0, core_rx_tready;
  logic out_tlast, out_tvalid, out_tready = 0;

  grid_unit_stage #(.DW(DW), .UNIT_IDX(UNIT), .CDC_DEPTH(CDC_D), .BYP_DEPTH(BYP_D)) uut (
    .clk_fab(clk_fab), .rst_fab_n(rst_fab_n), .clk_core(clk_core), .rst_core_n(rst_core_n),
    .in_tdata(in_tdata), .in_tlast(in_tlast), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .core_tx_tdata(core_tx_tdata), .core_tx_tlast(core_tx_tlast),
    .core_tx_tvalid(core_tx_tvalid), .core_tx_tready(core_tx_tready),
    .core_rx_tdata(core_rx_tdata), .core_rx_tlast(core_rx_tlast),
    .core_rx_tvalid(core_rx_tvalid), .core_rx_tready(core_rx_tready),
    .out_tdata(out_tdata), .out_tlast(out_tlast), .out_tvalid(out_tvalid), .out_tready(out_tready)
  );

  int checks = 0, fails = 0, accepted = 0, cyc = 0;
  logic [32:0] exp_tx[$], exp_core[$], exp_byp[$], ret_q[$], rx_buf[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  // core model: checks beats leaving the stage, returns them tagged with bit 31 plus a trailer
  bit core_stall = 0, rx_pend = 0;
  always @(negedge clk_core) begin
    if (rst_core_n) begin
      if (rx_pend) void'(ret_q.pop_front());
      if (ret_q.size() != 0) begin
        core_rx_tvalid = 1;
        {core_rx_tlast, core_rx_tdata} = ret_q[0];
      end else core_rx_tvalid = 0;
      rx_pend = core_rx_tvalid && core_rx_tready;
      core_tx_tready = core_stall ? ($urandom % 3 != 0) : 1'b1;
      if (core_tx_tvalid && core_tx_tready) begin
        logic [32:0] beat, e;
        beat = {core_tx_tlast, core_tx_tdata};
        if (exp_tx.size() == 0) check(0, "R2 unexpected core beat", beat, 0);
        else begin
          e = exp_tx.pop_front();
          check(beat == e, "R2/R5 core port beat", beat, e);
        end
        rx_buf.push_back(beat);
        if (core_tx_tlast) begin
          foreach (rx_buf[i]) begin
            logic [32:0] r;
            r = {1'b0, rx_buf[i][31:0] | 32'h8000_0000};
            ret_q.push_back(r);
            exp_core.push_back(r);
          end
          ret_q.push_back({1'b1, 32'h8000_0000 | 32'(rx_buf.size())});
          exp_core.push_back({1'b1, 32'h8000_0000 | 32'(rx_buf.size())});
          rx_buf.delete();
        end
      end
    end
  end

  // output monitor: every fabric cycle
  bit out_hold = 0, out_thr = 0, rr_chk = 0, prev_stall = 0, mid = 0, cur_src = 0, prev_src = 0;
  int rr_cnt = 0;
  logic [32:0] prev_beat = '0;
  always @(negedge clk_fab) begin
    if (rst_fab_n) begin
      if (prev_stall)
        check(out_tvalid && ({out_tlast, out_tdata} == prev_beat), "R8 held output",
              {out_tvalid, out_tlast, out_tdata}, {1'b1, prev_beat});
      out_tready = out_hold ? 1'b0 : (out_thr ? ($urandom % 2 == 1) : 1'b1);
      prev_stall = out_tvalid && !out_tready;
      prev_beat  = {out_tlast, out_tdata};
      if (out_tvalid && out_tready) begin
        logic [32:0] beat, e;
        beat = {out_tlast, out_tdata};
        if (!mid) begin
          cur_src = out_tdata[31];
          if (rr_chk) begin
            if (rr_cnt > 0) check(cur_src != prev_src, "R7 alternation", cur_src, !prev_src);
            rr_cnt++;
          end
        end else check(out_tdata[31] == cur_src, "R6 packet interleave", out_tdata[31], cur_src);
        if (cur_src) begin
          if (exp_core.size() == 0) check(0, "R10 unexpected returned beat", beat, 0);
          else begin e = exp_core.pop_front(); check(beat == e, "R10 returned beat", beat, e); end
        end else begin
          if (exp_byp.size() == 0) check(0, "R3 unexpected bypass beat", beat, 0);
          else begin e = exp_byp.pop_front(); check(beat == e, "R3 bypass beat", beat, e); end
        end
        mid = !out_tlast;
        if (out_tlast) prev_src = cur_src;
      end
    end
  end

  always @(posedge clk_fab) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; fails++;
      $display("FAIL R5 watchdog actual=hang expected=completion");
      report();
    end
  end

  task automatic send_pkt(input bit to_core, input int len);
    for (int i = 0; i < len; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[31] = 1'b0;
      if (i == 0) d[27+UNIT] = to_core;   // R4: later beats keep random route bits
      @(negedge clk_fab);
      in_tvalid = 1; in_tdata = d; in_tlast = (i == len - 1);
      forever begin
        #1;
        if (in_tready) break;
        @(negedge clk_fab);
      end
      @(posedge clk_fab);
      accepted++;
      if (to_core) exp_tx.push_back({in_tlast, d});
      else         exp_byp.push_back({in_tlast, d});
    end
    @(negedge clk_fab);
    in_tvalid = 0;
  endtask

  task automatic drain(input string req);
    int n = 0;
    while ((exp_tx.size() != 0 || exp_core.size() != 0 || exp_byp.size() != 0 ||
            ret_q.size() != 0) && n < 3000) begin
      @(negedge clk_fab);
      n++;
    end
    check(n < 3000, req, n, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk_fab);
    rst_fab_n = 1; rst_core_n = 1;
    @(negedge clk_fab); #1;
    check(out_tvalid == 0, "R1 out_tvalid", out_tvalid, 0);
    check(core_tx_tvalid == 0, "R1 core_tx_tvalid", core_tx_tvalid, 0);
    check(in_tready == 1, "R1 in_tready", in_tready, 1);

    send_pkt(0, 1); send_pkt(0, 2); send_pkt(0, 5);
    drain("R3 bypass drained");

    core_stall = 1;
    send_pkt(1, 1); send_pkt(1, 3); send_pkt(1, 6);
    drain("R5 core path drained");

    out_thr = 1;
    for (int k = 0; k < 40; k++) send_pkt(1'($urandom % 2), 1 + int'($urandom % 8));
    drain("R4 mixed traffic drained");
    out_thr = 0; core_stall = 0;

    out_hold = 1; accepted = 0;
    fork
      send_pkt(0, 20);
      begin
        repeat (60) @(negedge clk_fab);
        #2;
        check(accepted == BYP_D, "R9 beats taken while full", accepted, BYP_D);
        check(in_tready == 0, "R9 in_tready while full", in_tready, 0);
        out_hold = 0;
      end
    join
    drain("R9 long packet drained");

    out_hold = 1;
    send_pkt(1, 2); send_pkt(0, 2); send_pkt(1, 2); send_pkt(0, 2);
    repeat (150) @(negedge clk_fab);
    rr_cnt = 0; rr_chk = 1; out_hold = 0;
    drain("R7 contention drained");
    rr_chk = 0;
    check(rr_cnt == 4, "R7 packet count", rr_cnt, 4);
    check(exp_tx.size() == 0 && exp_core.size() == 0 && exp_byp.size() == 0,
          "R5 nothing lost", exp_tx.size() + exp_core.size() + exp_byp.size(), 0);
    report();
  end
endmodule